// File: doc/BRIEF.md
# Register-File ALU Operation Sequencer

This block holds a small file of general registers and a single ALU. It runs one register-to-register operation at a time. A command names an operation, two source registers and a destination register, plus an immediate value that only the load operation uses. The sequencer then steps the ALU through as many clocked passes as the operation needs and writes the destination register in the last pass.

Addition takes one execute pass. Subtraction is done in three passes through an internal holding register: first the bitwise inverse of the B operand, then that value plus one, then A plus the negated B. There is no dedicated subtractor. A load operation copies the immediate into the destination in one pass, so the register file can be given known contents. A debug port reads any register combinationally at any time.

Commands use a valid/ready handshake. A transfer happens on a rising edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low for the whole time an operation is in flight. While it is low, the fields and `cmd_valid` have no effect, and the sender may change or drop them freely. Completion is a plain one-cycle `done` pulse, with the carry of the last ALU pass shown on `carry_out`.

Top module: `regalu_seq`

## Requirements
- R1: After synchronous reset, all registers read 0, `busy`, `done` and `carry_out` are 0, and `cmd_ready` is 1.
- R2: Opcode values 2 and 3 (bit 1 set) load `cmd_imm` into register `cmd_rd`. `done` is high in the second cycle after the accepting cycle.
- R3: Opcode 0 writes (reg[`cmd_rs_a`] + reg[`cmd_rs_b`]) mod 16 into `cmd_rd`. `done` is high in the second cycle after the accepting cycle. For example, 3 + 2 gives 5.
- R4: Opcode 1 writes (reg[`cmd_rs_a`] − reg[`cmd_rs_b`]) mod 16 into `cmd_rd`. It uses three ALU passes: NOT B, +1, then A + result. `busy` is high for exactly three cycles, and `done` is high in the fourth cycle after the accepting cycle.
- R5: When `done` rises, `carry_out` holds the carry out of the final ALU pass of that operation. For a load this carry is 0. For a subtraction it is the carry of A + ((~B + 1) mod 16).
- R6: `cmd_ready` is the inverse of `busy`. A `cmd_valid` presented while busy is ignored and changes no register.
- R7: When the destination equals a source, the result uses the source values from before the operation.
- R8: `done` is a single-cycle pulse. It follows only the cycle in which the destination is written, and `busy` is low while `done` is high.
- R9: `dbg_data` shows the register selected by `dbg_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_op | input | 2 | 0 add, 1 subtract, 2/3 load immediate |
| cmd_rs_a | input | 2 | Index of source A |
| cmd_rs_b | input | 2 | Index of source B |
| cmd_rd | input | 2 | Index of destination |
| cmd_imm | input | 4 | Immediate for load |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 1 | Carry of last ALU pass |
| dbg_sel | input | 2 | Register index for debug read |
| dbg_data | output | 4 | Contents of selected register |

## Verification
The bench first loads known values. It then runs the basic 3 + 2 addition and a self-addition that overflows, which separates correct modulo-16 wrap and carry from a missing carry. Subtractions are run with a positive result, a negative result, a zero result and B equal to zero. These show whether the invert and increment passes happen in the right order, and whether the final carry comes from the last pass and not the increment pass. Several operations write a register that is also one of their sources, which exposes any early write. One command is offered while busy, and a full register sweep then shows that nothing changed.

// File: rtl/regalu_pkg.sv
package regalu_pkg;
  localparam int OP_W = 2;

  typedef enum logic [1:0] {
    FN_ADD  = 2'd0,
    FN_NOT  = 2'd1,
    FN_PASS = 2'd2
  } alu_fn_e;

  typedef enum logic [1:0] {
    XS_RA    = 2'd0,
    XS_RB    = 2'd1,
    XS_INTER = 2'd2,
    XS_IMM   = 2'd3
  } xsel_e;

  typedef enum logic [1:0] {
    YS_RB    = 2'd0,
    YS_INTER = 2'd1,
    YS_ZERO  = 2'd2
  } ysel_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADD    = 3'd1,
    ST_LOAD   = 3'd2,
    ST_INV    = 3'd3,
    ST_INC    = 3'd4,
    ST_SUBADD = 3'd5
  } seq_state_e;
endpackage

// File: rtl/regalu_regfile.sv
module regalu_regfile #(
  parameter int DATA_W = 4,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b,
  input  logic [IDX_W-1:0]  raddr_d,
  output logic [DATA_W-1:0] rdata_d
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && (waddr == IDX_W'(g)))
        regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_d = regs[raddr_d];
endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
  import regalu_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic [DATA_W:0] wide;

  always_comb begin
    case (fn)
      FN_ADD:  wide = (DATA_W+1)'(x) + (DATA_W+1)'(y) + (DATA_W+1)'(cin);
      FN_NOT:  wide = {1'b0, ~x};
      FN_PASS: wide = {1'b0, x};
      default: wide = '0;
    endcase
  end

  assign res  = wide[DATA_W-1:0];
  assign cout = wide[DATA_W];
endmodule

// File: rtl/regalu_ctrl.sv
module regalu_ctrl
  import regalu_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [IDX_W-1:0]  cmd_rs_a,
  input  logic [IDX_W-1:0]  cmd_rs_b,
  input  logic [IDX_W-1:0]  cmd_rd,
  input  logic [DATA_W-1:0] cmd_imm,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  sel_a,
  output logic [IDX_W-1:0]  sel_b,
  output logic [IDX_W-1:0]  sel_d,
  output logic [DATA_W-1:0] imm_q,
  output alu_fn_e           alu_fn,
  output xsel_e             x_sel,
  output ysel_e             y_sel,
  output logic              alu_cin,
  output logic              inter_we,
  output logic              rf_we
);
  seq_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      sel_a <= '0;
      sel_b <= '0;
      sel_d <= '0;
      imm_q <= '0;
    end else begin
      done <= rf_we;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            sel_a <= cmd_rs_a;
            sel_b <= cmd_rs_b;
            sel_d <= cmd_rd;
            imm_q <= cmd_imm;
            if (cmd_op[1])      state <= ST_LOAD;
            else if (cmd_op[0]) state <= ST_INV;
            else                state <= ST_ADD;
          end
        end
        ST_INV:    state <= ST_INC;
        ST_INC:    state <= ST_SUBADD;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    alu_fn   = FN_ADD;
    x_sel    = XS_RA;
    y_sel    = YS_RB;
    alu_cin  = 1'b0;
    inter_we = 1'b0;
    rf_we    = 1'b0;
    case (state)
      ST_ADD: rf_we = 1'b1;
      ST_LOAD: begin
        alu_fn = FN_PASS;
        x_sel  = XS_IMM;
        rf_we  = 1'b1;
      end
      ST_INV: begin
        alu_fn   = FN_NOT;
        x_sel    = XS_RB;
        inter_we = 1'b1;
      end
      ST_INC: begin
        x_sel    = XS_INTER;
        y_sel    = YS_ZERO;
        alu_cin  = 1'b1;
        inter_we = 1'b1;
      end
      ST_SUBADD: begin
        y_sel = YS_INTER;
        rf_we = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign cmd_ready = (state == ST_IDLE);
endmodule

// File: rtl/regalu_seq.sv
module regalu_seq
  import regalu_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [IDX_W-1:0]  cmd_rs_a,
  input  logic [IDX_W-1:0]  cmd_rs_b,
  input  logic [IDX_W-1:0]  cmd_rd,
  input  logic [DATA_W-1:0] cmd_imm,
  output logic              busy,
  output logic              done,
  output logic              carry_out,
  input  logic [IDX_W-1:0]  dbg_sel,
  output logic [DATA_W-1:0] dbg_data
);
  logic [IDX_W-1:0]  sel_a, sel_b, sel_d;
  logic [DATA_W-1:0] imm_q, rd_a, rd_b, inter_q;
  logic [DATA_W-1:0] alu_x, alu_y, alu_res;
  logic              alu_cin, alu_cout, inter_we, rf_we;
  alu_fn_e           alu_fn;
  xsel_e             x_sel;
  ysel_e             y_sel;

  regalu_ctrl #(.DATA_W(DATA_W), .NREG(NREG)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_rs_a(cmd_rs_a), .cmd_rs_b(cmd_rs_b), .cmd_rd(cmd_rd), .cmd_imm(cmd_imm),
    .busy(busy), .done(done),
    .sel_a(sel_a), .sel_b(sel_b), .sel_d(sel_d), .imm_q(imm_q),
    .alu_fn(alu_fn), .x_sel(x_sel), .y_sel(y_sel), .alu_cin(alu_cin),
    .inter_we(inter_we), .rf_we(rf_we)
  );

  regalu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .we(rf_we), .waddr(sel_d), .wdata(alu_res),
    .raddr_a(sel_a), .rdata_a(rd_a),
    .raddr_b(sel_b), .rdata_b(rd_b),
    .raddr_d(dbg_sel), .rdata_d(dbg_data)
  );

  always_comb begin
    case (x_sel)
      XS_RA:    alu_x = rd_a;
      XS_RB:    alu_x = rd_b;
      XS_INTER: alu_x = inter_q;
      default:  alu_x = imm_q;
    endcase
    case (y_sel)
      YS_RB:    alu_y = rd_b;
      YS_INTER: alu_y = inter_q;
      default:  alu_y = '0;
    endcase
  end

  regalu_alu #(.DATA_W(DATA_W)) u_alu (
    .fn(alu_fn), .x(alu_x), .y(alu_y), .cin(alu_cin),
    .res(alu_res), .cout(alu_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      inter_q   <= '0;
      carry_out <= 1'b0;
    end else begin
      if (inter_we) inter_q   <= alu_res;
      if (rf_we)    carry_out <= alu_cout;
    end
  end
endmodule

// File: rtl/regalu_chk.sv
module regalu_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic rf_we,
  input logic inter_we
);
  logic [2:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + 3'd1;
    else           busy_run <= '0;
  end

  // R4: no operation keeps the sequencer busy longer than three cycles
  p_busy_max_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run < 3'd3));

  // R6: an operation in flight stays in flight until its write, whatever cmd_valid does
  p_hold_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !rf_we && cmd_valid) |=> busy);

  // R8: destination writes happen only while busy and are followed by done
  p_write_busy_r8: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> busy);

  p_done_after_write_r8: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R4: intermediate passes never coincide with the destination write
  p_inter_excl_r4: assert property (@(posedge clk) disable iff (rst)
    inter_we |-> (busy && !rf_we));
endmodule

bind regalu_seq regalu_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy),
  .done(done), .rf_we(rf_we), .inter_we(inter_we)
);

// File: tb/regalu_seq_bench.sv
`timescale 1ns/1ps
module regalu_seq_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [1:0] cmd_op;
  logic [1:0] cmd_rs_a, cmd_rs_b, cmd_rd;
  logic [3:0] cmd_imm;
  logic       busy, done, carry_out;
  logic [1:0] dbg_sel;
  logic [3:0] dbg_data;

  always #2.5 clk = ~clk;

  regalu_seq u_regalu_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_rs_a(cmd_rs_a), .cmd_rs_b(cmd_rs_b), .cmd_rd(cmd_rd),
    .cmd_imm(cmd_imm), .busy(busy), .done(done), .carry_out(carry_out),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  typedef struct {
    logic [1:0] rd;
    logic [3:0] val;
    logic       cy;
    int         lat;
    int         t0;
    string      req;
  } exp_t;

  exp_t       sb[$];
  int         n_run = 0, n_fail = 0;
  int         cyc = 0;
  int         issued = 0, retired = 0;
  logic [3:0] mdl [4];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops an expected item on every done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (sb.size() == 0) begin
          chk("R8", "done without pending op", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.req, "done latency", cyc - e.t0, e.lat);
          chk("R8", "busy low with done", int'(busy), 0);
          chk("R5", "carry_out", int'(carry_out), int'(e.cy));
          dbg_sel = e.rd;
          #0.5;
          chk(e.req, "destination value", int'(dbg_data), int'(e.val));
          retired++;
        end
      end
    end
  end

  // driver: op 0 add, 1 sub, 2 load; inject=1 offers a load while busy
  task automatic issue(input logic [1:0] op, input logic [1:0] a, input logic [1:0] b,
                       input logic [1:0] d, input logic [3:0] imm, input bit inject,
                       input string req);
    exp_t e;
    logic [4:0] s;
    logic [3:0] neg;
    @(negedge clk);
    chk("R6", "ready while idle", int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_rs_a = a; cmd_rs_b = b; cmd_rd = d; cmd_imm = imm;
    e.rd = d; e.t0 = cyc; e.req = req;
    if (op[1]) begin
      e.val = imm; e.cy = 1'b0; e.lat = 2;
    end else if (op[0]) begin
      neg = 4'(~mdl[b] + 4'd1);
      s = 5'(mdl[a]) + 5'(neg);
      e.val = s[3:0]; e.cy = s[4]; e.lat = 4;
    end else begin
      s = 5'(mdl[a]) + 5'(mdl[b]);
      e.val = s[3:0]; e.cy = s[4]; e.lat = 2;
    end
    mdl[d] = e.val;
    sb.push_back(e);
    issued++;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6", "busy after accept", int'(busy), 1);
    chk("R6", "ready low while busy", int'(cmd_ready), 0);
    if (inject) begin
      cmd_valid = 1'b1; cmd_op = 2'd2; cmd_rd = 2'd3; cmd_imm = 4'hF;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (retired != issued) @(negedge clk);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 4; i++) begin
      dbg_sel = 2'(i);
      #0.5;
      chk(req, $sformatf("register %0d", i), int'(dbg_data), int'(mdl[i]));
    end
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_rs_a = '0; cmd_rs_b = '0;
    cmd_rd = '0; cmd_imm = '0; dbg_sel = '0;
    for (int i = 0; i < 4; i++) mdl[i] = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "carry_out", int'(carry_out), 0);
    chk("R1", "ready", int'(cmd_ready), 1);
    sweep("R1");

    issue(2'd2, 2'd0, 2'd0, 2'd0, 4'd3, 1'b0, "R2");   // load R0 = 3
    issue(2'd3, 2'd0, 2'd0, 2'd1, 4'd2, 1'b0, "R2");   // load R1 = 2 via opcode 3
    issue(2'd0, 2'd0, 2'd1, 2'd2, 4'd0, 1'b0, "R3");   // 3 + 2 = 5
    issue(2'd2, 2'd0, 2'd0, 2'd3, 4'd9, 1'b0, "R2");   // load R3 = 9
    issue(2'd0, 2'd3, 2'd3, 2'd3, 4'd0, 1'b0, "R7");   // 9 + 9 wraps, rd aliases both
    issue(2'd1, 2'd0, 2'd1, 2'd1, 4'd0, 1'b0, "R7");   // 3 - 2, rd aliases B
    issue(2'd1, 2'd1, 2'd0, 2'd0, 4'd0, 1'b1, "R4");   // 1 - 3 negative, start offered while busy
    sweep("R6");
    issue(2'd1, 2'd2, 2'd2, 2'd2, 4'd0, 1'b0, "R4");   // 5 - 5 = 0
    issue(2'd2, 2'd0, 2'd0, 2'd3, 4'd0, 1'b0, "R2");   // load R3 = 0
    issue(2'd1, 2'd1, 2'd3, 2'd3, 4'd0, 1'b0, "R4");   // B = 0 subtraction
    for (int i = 0; i < 4; i++) begin
      dbg_sel = 2'(i);
      #0.5;
      chk("R9", "debug read", int'(dbg_data), int'(mdl[i]));
    end
    chk("R8", "queue drained", sb.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule